// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block runs the data phase of an I2C bus master, one transfer at a time. When `go_i` starts a transfer, it moves a programmable number of bits, from 1 to 8, most significant bit first. In transmit mode it shifts the bits out on SDA. In receive mode it samples them in from SDA. It can add one acknowledge clock slot after the data bits. In that slot a transmitter releases SDA and records the receiver's answer, and a receiver pulls SDA low to acknowledge the byte.

SCL timing comes from an external divider. The divider gives a one-cycle strobe, `tick_i`, and each strobe ends the current SCL half-period. SDA is modelled as open drain: `sda_oe_o` high means the line is pulled low. START and STOP generation, arbitration and slave addressing belong to neighbouring logic.

The bit-count code is held in a register. A write loads it, and it keeps its value until the next write. The neighbouring START generator pulses `bus_start_i` each time it issues a start condition, and that pulse clears the code. The address byte that follows a start therefore always moves 8 bits.

Top module: `i2c_xfer_engine`

## Requirements
- R1: After reset, `scl_o` is 1 (released), `sda_oe_o` is 0, `done_o` is 0, `rx_byte_o` is 0x00, `ack_o` is 1, and the stored bit-count code is 000.
- R2: A cycle with `code_wr_i`=1 loads `code_i` into the bit-count register, and the register holds that value until the next write. Code 000 selects 8 bits, and codes 001 to 111 select 1 to 7 bits.
- R3: A cycle with `bus_start_i`=1 clears the bit-count register to 000, so the next transfer moves 8 bits. The clear takes priority over a write in the same cycle.
- R4: In transmit mode (`rx_mode_i`=0), the n data bits are `tx_byte_i[7]` down to `tx_byte_i[8-n]`, in that order. Each bit is driven during its SCL low and high phases, with `sda_oe_o`=1 for a 0 bit and `sda_oe_o`=0 for a 1 bit.
- R5: In receive mode, SDA is sampled at each SCL rising edge and shifted in MSB first. The n received bits sit right-aligned in `rx_byte_o`, and the upper bits are 0. `rx_byte_o` updates in the same cycle that `done_o` rises.
- R6: `sda_oe_o` never changes while `scl_o` stays high.
- R7: With `ack_en_i`=1, exactly one SCL pulse follows the data bits. In transmit mode `sda_oe_o` is 0 during that slot, and the SDA level at the slot's rising edge is latched into `ack_o`.
- R8: With `ack_en_i`=1 in receive mode, `sda_oe_o` is 1 throughout the acknowledge slot, and `ack_o` keeps its previous value.
- R9: With `ack_en_i`=0, exactly n SCL pulses are produced, and `ack_o` keeps its previous value.
- R10: `done_o` is high for exactly one cycle, on the strobe that ends the high phase of the last pulse. At that point `scl_o` is 0 and `sda_oe_o` is 0.
- R11: A `go_i` pulse that arrives while a transfer is running is ignored. The running transfer keeps its pulse count, its data and its direction.
- R12: Each SCL phase lasts until the next `tick_i`. `scl_o` changes only in the cycle after a strobe, or in the cycle after an accepted `go_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| code_wr_i | input | 1 | Write strobe for the bit-count code |
| code_i | input | 3 | Bit-count code (000 = 8 bits) |
| bus_start_i | input | 1 | Start condition issued; clears the bit-count code |
| go_i | input | 1 | Begin one transfer |
| rx_mode_i | input | 1 | 1 = receive, 0 = transmit (latched at go) |
| ack_en_i | input | 1 | 1 = append acknowledge slot (latched at go) |
| tx_byte_i | input | 8 | Byte to transmit (latched at go) |
| tick_i | input | 1 | SCL half-period strobe from the divider |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| scl_o | output | 1 | SCL level driven by the master |
| rx_byte_o | output | 8 | Received bits, right-aligned |
| ack_o | output | 1 | Acknowledge level sampled in transmit mode |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
A wrong remaining-bit count shows at the ports within one transfer. The number of SCL pulses before `done_o` is off, and in receive mode the received byte comes out misaligned. A wrong phase state or a wrong shift-register step shows as SDA moving while SCL is high, or as the wrong bit on the line. Either appears at the first SCL rising edge after the fault. A corrupted code register, or a start clear that does not take effect, shows only on the next transfer, as the wrong bit count.

// File: rtl/i2c_xfer_pkg.sv
package i2c_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LO   = 3'd1,
    ST_HI   = 3'd2,
    ST_AKLO = 3'd3,
    ST_AKHI = 3'd4
  } phase_t;

  // Number of data bits selected by a count code; the all-zero code means a full word.
  function automatic int unsigned bits_from_code(input logic [2:0] code, input int unsigned width);
    if (code == 3'd0) return width;
    return int'(code);
  endfunction

  // Total SCL pulses of one transfer.
  function automatic int unsigned pulses_of(input int unsigned nbits, input logic ack_en);
    return nbits + (ack_en ? 1 : 0);
  endfunction

endpackage

// File: rtl/i2c_bit_tally.sv
module i2c_bit_tally
  import i2c_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_wr,
  input  logic [CODE_W-1:0] code_in,
  input  logic              bus_start,
  input  logic              load,
  input  logic              step,
  output logic [CODE_W-1:0] code_q,
  output logic [CNT_W-1:0]  left_q,
  output logic              last_bit
);

  logic [CNT_W-1:0] load_val;

  always_comb begin
    load_val = CNT_W'(bits_from_code(code_q, DATA_W));
  end

  // Code register: the start-condition clear wins over a write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
    end else if (bus_start) begin
      code_q <= '0;
    end else if (code_wr) begin
      code_q <= code_in;
    end
  end

  // Remaining data bits of the running transfer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_val;
    end else if (step && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign last_bit = (left_q == CNT_W'(1));

  // R3: one cycle after a start condition, the code reads zero.
  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (code_q == '0));

  // R2: with no write and no start, the code holds.
  assert_code_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_start && !code_wr) |=> $stable(code_q));

  // R2: a loaded count always lies between 1 and DATA_W.
  assert_load_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (left_q >= CNT_W'(1) && left_q <= CNT_W'(DATA_W)));

endmodule

// File: rtl/i2c_shifter.sv
module i2c_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_step,
  input  logic              rx_sample,
  input  logic              sda_in,
  output logic              tx_bit,
  output logic [DATA_W-1:0] rx_word
);

  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
    end else if (load) begin
      tx_sh <= tx_byte;
    end else if (tx_step) begin
      tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh <= '0;
    end else if (load) begin
      rx_sh <= '0;
    end else if (rx_sample) begin
      rx_sh <= {rx_sh[DATA_W-2:0], sda_in};
    end
  end

  assign tx_bit  = tx_sh[DATA_W-1];
  assign rx_word = rx_sh;

  // R4: the outgoing bit can only move when the shifter steps or reloads.
  assert_txbit_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tx_step) |=> $stable(tx_bit));

endmodule

// File: rtl/i2c_phase_fsm.sv
module i2c_phase_fsm
  import i2c_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1),
  localparam int unsigned PUL_W = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              rx_mode,
  input  logic              ack_en,
  input  logic              tick,
  input  logic              sda_in,
  input  logic              last_bit,
  input  logic [CNT_W-1:0]  load_bits,
  input  logic [DATA_W-1:0] rx_word,
  output phase_t            phase_q,
  output logic              rx_mode_q,
  output logic              ev_go,
  output logic              ev_rise,
  output logic              ev_data_rise,
  output logic              ev_next_bit,
  output logic              ev_finish,
  output logic              scl_q,
  output logic              done_q,
  output logic              ack_q,
  output logic [DATA_W-1:0] rx_byte_q
);

  logic ack_en_q;
  logic ev_to_ack;
  logic ev_ack_rise;

  // Named internal events shared by the shifter, the counter and the checks.
  assign ev_go        = go && (phase_q == ST_IDLE);
  assign ev_data_rise = tick && (phase_q == ST_LO);
  assign ev_ack_rise  = tick && (phase_q == ST_AKLO);
  assign ev_rise      = ev_data_rise || ev_ack_rise;
  assign ev_next_bit  = tick && (phase_q == ST_HI) && !last_bit;
  assign ev_to_ack    = tick && (phase_q == ST_HI) && last_bit && ack_en_q;
  assign ev_finish    = tick && (((phase_q == ST_HI) && last_bit && !ack_en_q)
                                 || (phase_q == ST_AKHI));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= ST_IDLE;
      rx_mode_q <= 1'b0;
      ack_en_q  <= 1'b0;
    end else begin
      if (ev_go) begin
        phase_q   <= ST_LO;
        rx_mode_q <= rx_mode;
        ack_en_q  <= ack_en;
      end else if (ev_data_rise) begin
        phase_q <= ST_HI;
      end else if (ev_next_bit) begin
        phase_q <= ST_LO;
      end else if (ev_to_ack) begin
        phase_q <= ST_AKLO;
      end else if (ev_ack_rise) begin
        phase_q <= ST_AKHI;
      end else if (ev_finish) begin
        phase_q <= ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
    end else if (ev_rise) begin
      scl_q <= 1'b1;
    end else if (ev_go || ev_next_bit || ev_to_ack || ev_finish) begin
      scl_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      rx_byte_q <= '0;
      ack_q     <= 1'b1;
    end else begin
      done_q <= ev_finish;
      if (ev_finish) begin
        rx_byte_q <= rx_word;
      end
      if (ev_ack_rise && !rx_mode_q) begin
        ack_q <= sda_in;
      end
    end
  end

  // Pulse bookkeeping used only by the checks below.
  logic [PUL_W-1:0] pulse_cnt;
  logic [PUL_W-1:0] pulse_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_cnt <= '0;
      pulse_exp <= '0;
    end else if (ev_go) begin
      pulse_cnt <= '0;
      pulse_exp <= PUL_W'(pulses_of(int'(load_bits), ack_en));
    end else if (ev_rise) begin
      pulse_cnt <= pulse_cnt + 1'b1;
    end
  end

  // R7 and R9: the finishing strobe comes after exactly n (+1) pulses.
  assert_pulse_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |-> (pulse_cnt == pulse_exp));

  // R10: done lasts a single cycle and the engine is idle with SCL low.
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (phase_q == ST_IDLE && !scl_q));

  // R12: SCL moves only after a strobe or an accepted go.
  assert_scl_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ev_go) |=> $stable(scl_q));

  // R11: direction is frozen while a transfer runs.
  assert_dir_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != ST_IDLE) |=> $stable(rx_mode_q));

  // R8 and R9: the acknowledge status moves only on a transmit ack-slot rising edge.
  assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_ack_rise && !rx_mode_q) |=> $stable(ack_q));

endmodule

// File: rtl/i2c_xfer_engine.sv
module i2c_xfer_engine
  import i2c_xfer_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CODE_W = 3,
  localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_wr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              bus_start_i,
  input  logic              go_i,
  input  logic              rx_mode_i,
  input  logic              ack_en_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tick_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic              scl_o,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              ack_o,
  output logic              done_o
);

  phase_t            phase_q;
  logic              rx_mode_q;
  logic              ev_go, ev_rise, ev_data_rise, ev_next_bit, ev_finish;
  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  load_bits;
  logic              last_bit;
  logic              tx_bit;
  logic [DATA_W-1:0] rx_word;
  logic              scl_q, done_q, ack_q;
  logic [DATA_W-1:0] rx_byte_q;

  assign load_bits = CNT_W'(bits_from_code(code_q, DATA_W));

  i2c_bit_tally #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_wr   (code_wr_i),
    .code_in   (code_i),
    .bus_start (bus_start_i),
    .load      (ev_go),
    .step      (ev_next_bit),
    .code_q    (code_q),
    .left_q    (left_q),
    .last_bit  (last_bit)
  );

  i2c_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_go),
    .tx_byte   (tx_byte_i),
    .tx_step   (ev_next_bit),
    .rx_sample (ev_data_rise),
    .sda_in    (sda_i),
    .tx_bit    (tx_bit),
    .rx_word   (rx_word)
  );

  i2c_phase_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .go           (go_i),
    .rx_mode      (rx_mode_i),
    .ack_en       (ack_en_i),
    .tick         (tick_i),
    .sda_in       (sda_i),
    .last_bit     (last_bit),
    .load_bits    (load_bits),
    .rx_word      (rx_word),
    .phase_q      (phase_q),
    .rx_mode_q    (rx_mode_q),
    .ev_go        (ev_go),
    .ev_rise      (ev_rise),
    .ev_data_rise (ev_data_rise),
    .ev_next_bit  (ev_next_bit),
    .ev_finish    (ev_finish),
    .scl_q        (scl_q),
    .done_q       (done_q),
    .ack_q        (ack_q),
    .rx_byte_q    (rx_byte_q)
  );

  logic in_data, in_ack;
  assign in_data = (phase_q == ST_LO) || (phase_q == ST_HI);
  assign in_ack  = (phase_q == ST_AKLO) || (phase_q == ST_AKHI);

  // Open-drain drive: transmit data pulls low for a zero, a receiver pulls low in the ack slot.
  assign sda_oe_o  = (in_data && !rx_mode_q && !tx_bit) || (in_ack && rx_mode_q);
  assign scl_o     = scl_q;
  assign rx_byte_o = rx_byte_q;
  assign ack_o     = ack_q;
  assign done_o    = done_q;

  // R6: while SCL stays high the SDA drive does not move.
  assert_sda_quiet_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_q) && scl_q) |-> $stable(sda_oe_o));

  // R4 and R5: the remaining-bit count only falls between bits and never underflows mid-transfer.
  assert_left_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (left_q != '0));

  // R11: a go during a transfer does not restart the counter.
  assert_go_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_data && !ev_next_bit) |=> $stable(left_q));

endmodule

// File: tb/i2c_xfer_engine_test.sv
module i2c_xfer_engine_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_wr_i = 1'b0;
  logic [2:0] code_i = 3'd0;
  logic       bus_start_i = 1'b0;
  logic       go_i = 1'b0;
  logic       rx_mode_i = 1'b0;
  logic       ack_en_i = 1'b0;
  logic [7:0] tx_byte_i = 8'h00;
  logic       tick_i = 1'b0;
  logic       sda_line;
  logic       sda_oe_o, scl_o, ack_o, done_o;
  logic [7:0] rx_byte_o;

  int compared = 0;
  int mismatched = 0;

  // Slave model state.
  logic [7:0] slave_byte = 8'hFF;
  logic       slave_ack = 1'b1;
  logic       slave_rx_mode = 1'b0;
  int         slave_n = 8;
  int         slave_idx = 0;
  int         rise_cnt = 0;
  logic [15:0] cap = 16'h0;
  int         done_cnt = 0;
  int         viol = 0;
  logic       slave_level;

  always #10 clk = ~clk;

  i2c_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .code_wr_i(code_wr_i), .code_i(code_i),
    .bus_start_i(bus_start_i), .go_i(go_i), .rx_mode_i(rx_mode_i),
    .ack_en_i(ack_en_i), .tx_byte_i(tx_byte_i), .tick_i(tick_i),
    .sda_i(sda_line), .sda_oe_o(sda_oe_o), .scl_o(scl_o),
    .rx_byte_o(rx_byte_o), .ack_o(ack_o), .done_o(done_o)
  );

  always_comb begin
    if (slave_idx < slave_n) slave_level = slave_rx_mode ? slave_byte[slave_n-1-slave_idx] : 1'b1;
    else if (slave_idx == slave_n) slave_level = slave_rx_mode ? 1'b1 : slave_ack;
    else slave_level = 1'b1;
  end
  assign sda_line = slave_level && !sda_oe_o;

  // Divider strobe: one cycle in four.
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div <= (tick_div == 3) ? 0 : tick_div + 1;
    tick_i   <= (tick_div == 3);
  end

  always @(posedge scl_o) begin
    cap      <= {cap[14:0], sda_line};
    rise_cnt <= rise_cnt + 1;
  end
  always @(negedge scl_o) slave_idx <= rise_cnt;

  logic prev_scl = 1'b0, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (done_o) done_cnt <= done_cnt + 1;
    if (rst_n && prev_scl && scl_o && (prev_oe != sda_oe_o)) viol <= viol + 1;
    prev_scl <= scl_o;
    prev_oe  <= sda_oe_o;
  end

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [2:0] c);
    return (c == 3'd0) ? 8 : int'(c);
  endfunction

  task automatic write_code(input logic [2:0] c, input logic with_start);
    @(negedge clk);
    code_i = c; code_wr_i = 1'b1; bus_start_i = with_start;
    @(negedge clk);
    code_wr_i = 1'b0; bus_start_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    bus_start_i = 1'b1;
    @(negedge clk);
    bus_start_i = 1'b0;
  endtask

  // Run one transfer; returns at the negedge where done is seen.
  task automatic run(input int n, input logic rxm, input logic acken,
                     input logic [7:0] txb, input logic [7:0] sb, input logic sack,
                     input logic busy_go, output logic [7:0] rx_at_done,
                     output logic scl_at_done, output logic oe_at_done);
    int guard;
    slave_n = n; slave_rx_mode = rxm; slave_byte = sb; slave_ack = sack;
    @(negedge clk);
    rise_cnt = 0; slave_idx = 0; done_cnt = 0; cap = 16'h0;
    rx_mode_i = rxm; ack_en_i = acken; tx_byte_i = txb; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    guard = 0;
    while (!done_o && guard < 400) begin
      if (busy_go && guard == 10) begin
        go_i = 1'b1; rx_mode_i = ~rxm; tx_byte_i = ~txb; ack_en_i = ~acken;
      end else begin
        go_i = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    go_i = 1'b0;
    if (guard >= 400) check("watchdog", 1, 0);
    rx_at_done = rx_byte_o; scl_at_done = scl_o; oe_at_done = sda_oe_o;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_tx(input string req, input logic [2:0] c, input logic [7:0] txb,
                      input logic acken, input logic sack, input logic busy_go);
    logic [7:0] rxd; logic sd, od; int n; int data_bits; logic ack_before;
    n = nbits(c);
    ack_before = ack_o;
    run(n, 1'b0, acken, txb, 8'h00, sack, busy_go, rxd, sd, od);
    check({req, " pulses"}, rise_cnt, n + (acken ? 1 : 0));
    data_bits = acken ? int'(cap >> 1) : int'(cap);
    data_bits = data_bits & ((1 << n) - 1);
    check({req, " R4 tx bits"}, data_bits, int'(txb) >> (8 - n));
    if (acken) begin
      check({req, " R7 ack released"}, int'(cap[0]), int'(sack));
      check({req, " R7 ack_o"}, int'(ack_o), int'(sack));
    end else begin
      check({req, " R9 ack_o held"}, int'(ack_o), int'(ack_before));
    end
    check({req, " R10 done width"}, done_cnt, 1);
    check({req, " R10 scl low"}, int'(sd), 0);
    check({req, " R10 sda released"}, int'(od), 0);
  endtask

  task automatic t_rx(input string req, input logic [2:0] c, input logic [7:0] sb,
                      input logic acken);
    logic [7:0] rxd; logic sd, od; int n; logic ack_before;
    n = nbits(c);
    ack_before = ack_o;
    run(n, 1'b1, acken, 8'h00, sb, 1'b1, 1'b0, rxd, sd, od);
    check({req, " pulses"}, rise_cnt, n + (acken ? 1 : 0));
    check({req, " R5 rx byte"}, int'(rxd), int'(sb) & ((1 << n) - 1));
    if (acken) check({req, " R8 ack driven low"}, int'(cap[0]), 0);
    check({req, " R8 ack_o held"}, int'(ack_o), int'(ack_before));
    check({req, " R10 done width"}, done_cnt, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check("watchdog", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 scl", int'(scl_o), 1);
    check("R1 sda_oe", int'(sda_oe_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 rx_byte", int'(rx_byte_o), 0);
    check("R1 ack", int'(ack_o), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1: stored code 000 gives 8 bits with no write
    t_tx("R1 default 8", 3'd0, 8'hA5, 1'b1, 1'b0, 1'b0);
    // R2: code 3 selects 3 bits, held across transfers
    write_code(3'd3, 1'b0);
    t_tx("R2 tx3", 3'd3, 8'hC3, 1'b1, 1'b1, 1'b0);
    t_rx("R2 rx3 held", 3'd3, 8'h05, 1'b1);
    write_code(3'd1, 1'b0);
    t_rx("R2 rx1", 3'd1, 8'h01, 1'b0);
    write_code(3'd7, 1'b0);
    t_tx("R9 tx7 noack", 3'd7, 8'h3C, 1'b0, 1'b0, 1'b0);
    // R3: start clears the code
    pulse_start();
    t_rx("R3 rx8 after start", 3'd0, 8'h96, 1'b1);
    // R3: clear beats a same-cycle write
    write_code(3'd2, 1'b1);
    t_tx("R3 priority", 3'd0, 8'h5A, 1'b0, 1'b0, 1'b0);
    // R5/R9 full byte receive without ack
    t_rx("R5 rx8 noack", 3'd0, 8'hE1, 1'b0);
    // R11: go while busy ignored
    t_tx("R11 busy go", 3'd0, 8'h81, 1'b1, 1'b0, 1'b1);
    // R7: nack level latched
    t_tx("R7 nack", 3'd0, 8'hFF, 1'b1, 1'b1, 1'b0);
    // R6 / R12 monitored throughout
    check("R6 sda quiet while scl high", viol, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule